// File: doc/BRIEF.md
# Selectable Clock Divider with Grouped Output Enables

This block picks one of two incoming clocks, a single-ended one and one that has already been received from a differential pair, and divides the chosen clock by 1, 2, 3 or 4 under a two-bit ratio code. The divided clock is copied onto several outputs that carry identical logic levels. Every ratio, the odd one included, gives an exact 50% high time. Divide by 3 combines a rising-edge modulo-3 flop with a falling-edge copy of it. Divide by 1 passes the selected clock straight through.

Each output comes with a per-pin drive enable that a pad cell uses to place the pin in high impedance. A two-bit enable code controls the outputs in two unequal groups. The first group is one output on its own and the second group is all the others. Integrators tie unused control inputs high. The all-ones setting therefore gives the differential source, divide by 4 and every output driven.

A ratio code change is taken up only when the internal counter wraps. The output period in progress always completes, and no shortened pulse appears. An active-low asynchronous reset parks the divider just before a wrap and holds the outputs low. The first output rising edge then lands on the first rising source edge after reset is released.

Top module: `clk_div_fanout`

## Requirements
- R1: `src_sel_i` = 0 selects `clk_se_i` and `src_sel_i` = 1 selects `clk_diff_i` as the clock that is divided.
- R2: `div_sel_i` codes 2'b00, 2'b01, 2'b10 and 2'b11 give output periods of 1, 2, 3 and 4 selected-source periods respectively.
- R3: `oe_i[0]` drives `clk_oe_o[0]` and `oe_i[1]` drives `clk_oe_o[3:1]`. Enable code 2'b00 turns all outputs off, 2'b01 turns on output 0 only, 2'b10 turns on outputs 1 to 3 only, and 2'b11 turns on all outputs.
- R4: The output high time is exactly half the output period for every ratio. This includes 1.5 source periods for divide by 3.
- R5: All bits of `clk_o` carry the same value at all times.
- R6: While `rst_ni` is low, `clk_o` is all zeros. After release, `clk_o` first rises on the first rising edge of the selected source.
- R7: A change of `div_sel_i` takes effect only when the counter wraps. The output period in progress completes at the old ratio.
- R8: While `div_sel_i` changes arbitrarily, no high or low phase of `clk_o` is shorter than half a selected-source period.
- R9: With all control inputs at 1, the block runs from `clk_diff_i` at divide by 4 with every output enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_se_i | input | 1 | Single-ended source clock |
| clk_diff_i | input | 1 | Source clock from the differential receiver |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_sel_i | input | 1 | Source select: 0 single-ended, 1 differential |
| div_sel_i | input | 2 | Ratio code: 00 /1, 01 /2, 10 /3, 11 /4 |
| oe_i | input | 2 | Group enables: bit 0 solo output, bit 1 remaining outputs |
| clk_o | output | NUM_OUT | Divided clock copies |
| clk_oe_o | output | NUM_OUT | Per-output pad drive enable, 0 = high impedance |

## Verification
The bench builds the block with its defaults: four outputs, one of them in the solo group. This makes both enable groups and every pairing of the enable code observable. The two sources run at 8 ns and 12 ns periods. An integer-nanosecond sampling grid therefore resolves every high time exactly, including the 12 ns high phase of divide by 3. Ratio changes injected mid-period expose both wrap-timed update and any runt phase.

// File: rtl/clk_div_pkg.sv
`timescale 1ns/1ps
package clk_div_pkg;
  localparam int unsigned DIV_W = 2;

  typedef enum logic [DIV_W-1:0] {
    DIV1 = 2'b00,
    DIV2 = 2'b01,
    DIV3 = 2'b10,
    DIV4 = 2'b11
  } div_e;
endpackage

// File: rtl/clk_src_mux.sv
`timescale 1ns/1ps
module clk_src_mux (
  input  logic clk_se_i,
  input  logic clk_diff_i,
  input  logic sel_i,
  output logic clk_o
);
  assign clk_o = sel_i ? clk_diff_i : clk_se_i;
endmodule

// File: rtl/clk_div_core.sv
`timescale 1ns/1ps
module clk_div_core
  import clk_div_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_sel_i,
  output logic             clk_o
);
  logic [DIV_W-1:0] cnt_q, cnt_nxt;
  div_e             ratio_q, ratio_nxt;
  logic             pos_q, neg_q;
  logic             wrap;

  // high phase decode for a given ratio and counter value
  function automatic logic hi_phase(div_e r, logic [DIV_W-1:0] c);
    case (r)
      DIV1:    hi_phase = 1'b1;
      DIV2:    hi_phase = (c == '0);
      DIV3:    hi_phase = (c == '0);
      default: hi_phase = (c < DIV_W'(2));
    endcase
  endfunction

  // counter terminal value equals the ratio code
  always_comb begin
    wrap      = (cnt_q == ratio_q);
    cnt_nxt   = wrap ? '0 : cnt_q + DIV_W'(1);
    ratio_nxt = wrap ? div_e'(div_sel_i) : ratio_q;
  end

  // reset parks one step before a wrap so the first edge is defined
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= DIV_W'(DIV4);
      ratio_q <= DIV4;
      pos_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      ratio_q <= ratio_nxt;
      pos_q   <= hi_phase(ratio_nxt, cnt_nxt);
    end
  end

  // falling-edge retime extends the /3 high phase by half a cycle
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= 1'b0;
    else         neg_q <= pos_q;
  end

  assign clk_o = (ratio_q == DIV1) ? clk_i : (pos_q | (neg_q & (ratio_q == DIV3)));

  p_cnt_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= ratio_q);

  p_ratio_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != ratio_q) |=> $stable(ratio_q));

  p_pulse_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pos_q) && (ratio_q inside {DIV2, DIV3})) |=> !pos_q);
endmodule

// File: rtl/clk_oe_decode.sv
`timescale 1ns/1ps
module clk_oe_decode #(
  parameter int unsigned NUM_OUT  = 4,
  parameter int unsigned SOLO_OUT = 1
) (
  input  logic [1:0]         oe_i,
  output logic [NUM_OUT-1:0] oe_o
);
  localparam int unsigned GRP_OUT = NUM_OUT - SOLO_OUT;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_oe
    if (i < SOLO_OUT) begin : g_solo
      assign oe_o[i] = oe_i[0];
    end else begin : g_grp
      assign oe_o[i] = oe_i[1];
    end
  end

  always_comb begin
    p_oe_group_r3: assert (($countones(oe_o[NUM_OUT-1:SOLO_OUT]) == 0) ||
                           ($countones(oe_o[NUM_OUT-1:SOLO_OUT]) == GRP_OUT));
  end
endmodule

// File: rtl/clk_div_fanout.sv
`timescale 1ns/1ps
module clk_div_fanout
  import clk_div_pkg::*;
#(
  parameter int unsigned NUM_OUT  = 4,
  parameter int unsigned SOLO_OUT = 1
) (
  input  logic               clk_se_i,
  input  logic               clk_diff_i,
  input  logic               rst_ni,
  input  logic               src_sel_i,
  input  logic [DIV_W-1:0]   div_sel_i,
  input  logic [1:0]         oe_i,
  output logic [NUM_OUT-1:0] clk_o,
  output logic [NUM_OUT-1:0] clk_oe_o
);
  logic clk_src;
  logic clk_div;

  clk_src_mux i_src_mux (
    .clk_se_i  (clk_se_i),
    .clk_diff_i(clk_diff_i),
    .sel_i     (src_sel_i),
    .clk_o     (clk_src)
  );

  clk_div_core i_div_core (
    .clk_i    (clk_src),
    .rst_ni   (rst_ni),
    .div_sel_i(div_sel_i),
    .clk_o    (clk_div)
  );

  clk_oe_decode #(
    .NUM_OUT (NUM_OUT),
    .SOLO_OUT(SOLO_OUT)
  ) i_oe_decode (
    .oe_i(oe_i),
    .oe_o(clk_oe_o)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_fan
    assign clk_o[i] = clk_div;
  end

  p_reset_low_r6: assert property (@(posedge clk_src) !rst_ni |-> (clk_o == '0));
endmodule

// File: tb/test_clk_div_fanout.sv
`timescale 1ns/1ps
module test_clk_div_fanout;
  localparam int NUM_OUT = 4;
  localparam int T_SE    = 8;   // 125 MHz
  localparam int T_DIFF  = 12;

  logic se_clk = 1'b0, diff_clk = 1'b0;
  logic rst_n = 1'b1, src_sel = 1'b0;
  logic [1:0] div_sel = 2'b11, oe = 2'b11;
  logic [NUM_OUT-1:0] clk_o, clk_oe_o;
  int n_tests = 0, n_fail = 0;

  always #(T_SE/2)   se_clk   = ~se_clk;
  always #(T_DIFF/2) diff_clk = ~diff_clk;

  clk_div_fanout #(.NUM_OUT(NUM_OUT), .SOLO_OUT(1)) i_clk_div_fanout (
    .clk_se_i(se_clk), .clk_diff_i(diff_clk), .rst_ni(rst_n),
    .src_sel_i(src_sel), .div_sel_i(div_sel), .oe_i(oe),
    .clk_o(clk_o), .clk_oe_o(clk_oe_o)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(inout bit same);
    #1;
    if (clk_o !== '0 && clk_o !== '1) same = 1'b0;
  endtask

  task automatic measure(output int per, output int hi, output bit same);
    int lo, g;
    same = 1'b1; g = 0; hi = 0; lo = 0;
    while (clk_o[0] !== 1'b0 && g < 400) begin step(same); g++; end
    while (clk_o[0] !== 1'b1 && g < 400) begin step(same); g++; end
    while (clk_o[0] === 1'b1 && g < 400) begin hi++; step(same); g++; end
    while (clk_o[0] === 1'b0 && g < 400) begin lo++; step(same); g++; end
    per = hi + lo;
  endtask

  task automatic t_reset;
    bit ok_low, seen, prev_se;
    ok_low = 1'b1; src_sel = 0; div_sel = 2'b11;
    rst_n = 1'b0;
    for (int i = 0; i < 20; i++) begin #1; if (clk_o !== '0) ok_low = 1'b0; end
    check(ok_low, "R6", "outputs low in reset", int'(clk_o), 0);
    rst_n = 1'b1;
    seen = 1'b0; prev_se = se_clk;
    for (int i = 0; i < 20 && !seen; i++) begin
      #1;
      if (!prev_se && se_clk) begin
        seen = 1'b1;
        check(clk_o === '1, "R6", "first edge on first source rise", int'(clk_o), 15);
      end else if (clk_o !== '0) ok_low = 1'b0;
      prev_se = se_clk;
    end
    check(ok_low && seen, "R6", "no early output edge", int'(ok_low), 1);
  endtask

  task automatic t_sweep(input bit src, input int tsrc);
    int per, hi; bit same;
    src_sel = src;
    for (int c = 0; c < 4; c++) begin
      div_sel = 2'(c);
      #120;
      measure(per, hi, same);
      check(per == (c + 1) * tsrc, src ? "R1/R2" : "R2", "period", per, (c + 1) * tsrc);
      check(hi * 2 == per && hi == (c + 1) * tsrc / 2, "R4", "high time", hi, (c + 1) * tsrc / 2);
      check(same, "R5", "outputs identical", int'(same), 1);
    end
  endtask

  task automatic t_oe;
    int per, hi; bit same;
    src_sel = 0; div_sel = 2'b11;
    for (int e = 0; e < 4; e++) begin
      oe = 2'(e);
      #1;
      check(clk_oe_o === {{3{oe[1]}}, oe[0]}, "R3", "enable pattern", int'(clk_oe_o), int'({{3{oe[1]}}, oe[0]}));
      measure(per, hi, same);
      check(per == 4 * T_SE && same, "R3", "clock runs under enable code", per, 4 * T_SE);
    end
    oe = 2'b11;
  endtask

  task automatic t_wrap;
    int per, hi, g, hic; bit same, seen_lo;
    same = 1'b1; src_sel = 0; div_sel = 2'b11; #120;
    g = 0;
    while (clk_o[0] !== 1'b0 && g < 100) begin step(same); g++; end
    while (clk_o[0] !== 1'b1 && g < 200) begin step(same); g++; end
    #1; div_sel = 2'b01;
    g = 0; hic = 0; seen_lo = 1'b0;
    while (!(seen_lo && clk_o[0] === 1'b1) && g < 100) begin
      step(same); g++;
      if (clk_o[0] === 1'b0) seen_lo = 1'b1;
      else if (!seen_lo) hic++;
    end
    check(hic == 14, "R7", "old high phase kept", hic, 14);
    check(g == 31, "R7", "old period completes", g, 31);
    measure(per, hi, same);
    check(per == 2 * T_SE && hi == T_SE, "R7", "new ratio after wrap", per, 2 * T_SE);
  endtask

  task automatic t_runt;
    int run, min_run; bit prev, started;
    src_sel = 0; div_sel = 2'b00; #50;
    min_run = 1000; run = 0; started = 1'b0; prev = clk_o[0];
    for (int k = 0; k < 40; k++) begin
      div_sel = 2'((k * 3 + 1) % 4);
      for (int s = 0; s < (k * 7) % 23 + 5; s++) begin
        #1;
        if (clk_o[0] !== prev) begin
          if (started && run < min_run) min_run = run;
          started = 1'b1; run = 1; prev = clk_o[0];
        end else run++;
      end
    end
    check(min_run >= T_SE / 2, "R8", "shortest phase", min_run, T_SE / 2);
  endtask

  task automatic t_default;
    int per, hi; bit same;
    src_sel = 1; div_sel = 2'b11; oe = 2'b11;
    rst_n = 1'b0; #10; rst_n = 1'b1; #60;
    check(clk_oe_o === '1, "R9", "all outputs enabled", int'(clk_oe_o), 15);
    measure(per, hi, same);
    check(per == 4 * T_DIFF && hi == 2 * T_DIFF, "R9", "diff source /4", per, 4 * T_DIFF);
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL R1..R9 watchdog: actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #0.5;
    t_reset();
    t_sweep(1'b0, T_SE);
    t_sweep(1'b1, T_DIFF);
    t_oe();
    t_wrap();
    t_runt();
    t_default();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule